// File: doc/BRIEF.md
# Windowed Register File for a Serial Card Target

This block sits on the card side of a serial flash-card link and answers register transactions. The link layer hands it a decoded 4-bit transaction code (already checked against its inverted copy) and then a stream of payload bytes in either direction. How many payload bytes a register transaction carries is never sent on the wire. It comes from a pair of windows, one for reading and one for writing. A dedicated setup transaction loads both windows before the register transactions that use them.

Every register byte that moves uses an address pointer, which advances by one after each byte. The status register, maintained by the card core, can be fetched with a one-byte status transaction. Between transactions the status register is also driven onto the data lines. In 4-bit width there is one status bit per lane. In 1-bit width the single line shows an OR summary, which serves as an interrupt request. A configuration register selects the bus width. Long-data transactions are passed on to the core only when the card reports that it is ready for data.

Top module: `card_regfile`

## Requirements
- R1: After reset the read and write window counts are zero. A register-read (code 0x4) or register-write (code 0xB) then reports a length of 0. The status register reads 0x00. `bus_4bit_o` is 0 (1-bit width).
- R2: Code 0x8 reports a length of 4 and takes four bytes in this order: read start, read count, write start, write count. The new windows apply from the next transaction.
- R3: Code 0xB reports a length equal to the write count. Its bytes go to consecutive addresses starting at the write start address. Bytes sent after the count is used up have no effect.
- R4: Code 0x4 reports a length equal to the read count. It returns on `rd_data_o` the bytes of consecutive addresses starting at the read start address, one byte per `rd_i` pulse, with the current byte visible before its pulse.
- R5: Code 0x7 reports a length of 1 and returns the status register, which is address 0x01.
- R6: Addresses 0x10 up to NREGS-1 are read/write storage. Any address at or beyond NREGS reads 0x00 and ignores writes. Addresses 0x00 to 0x0F are read-only: writes to them have no effect.
- R7: Address 0x04 reads 0x01, and addresses 0x06 and 0x07 read 0x00.
- R8: Register 0x10 resets to 0x80. `bus_4bit_o` is the inverse of its bit 7: 1 selects 4-bit width and 0 selects 1-bit width.
- R9: Long-read (0x2) and long-write (0xD) codes raise `long_go_o` for one cycle, in the cycle after the code, only if status bit 5 (ready for data) is set. Otherwise they are ignored.
- R10: While `idle_i` is high in 4-bit width, `dat_o[0..3]` show status bits 7, 6, 5 and 0. While `idle_i` is high in 1-bit width, `dat_o[0]` shows the OR of those four bits and `dat_o[3:1]` are 0. While `idle_i` is low, `dat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tpc_valid_i | input | 1 | Start of a transaction, code on tpc_i |
| tpc_i | input | 4 | Decoded transaction code |
| byte_valid_i | input | 1 | Host-to-card payload byte strobe |
| byte_i | input | DW | Host-to-card payload byte |
| rd_i | input | 1 | Card-to-host byte taken, advance pointer |
| rd_data_o | output | DW | Current card-to-host byte, 0 when none is due |
| xfer_len_o | output | DW | Payload length of the current transaction |
| long_go_o | output | 1 | Accepted long-data transaction pulse |
| sts_we_i | input | 1 | Core load of the status register |
| sts_i | input | DW | New status value |
| idle_i | input | 1 | Bus is between transactions |
| bus_4bit_o | output | 1 | 4-bit bus width selected |
| dat_o | output | 4 | Idle-state status on the data lanes |

## Verification
The assertions take for granted that the link layer never raises a transaction strobe in the same cycle as a payload strobe. They also assume the core does not reload the status register in the same cycle that a status transaction starts. The bench keeps every stimulus to one strobe per cycle and separates status loads from transaction codes by at least one idle cycle. Random windows stay inside a small address range that covers the read-only block, the storage block and the unimplemented space just above it, so that all three behaviours are exercised. Random write traffic sometimes sends surplus bytes.

// File: rtl/card_regfile_pkg.sv
package card_regfile_pkg;
  localparam logic [3:0] TPC_RD_LONG = 4'h2;
  localparam logic [3:0] TPC_RD_REG  = 4'h4;
  localparam logic [3:0] TPC_GET_STS = 4'h7;
  localparam logic [3:0] TPC_SET_WIN = 4'h8;
  localparam logic [3:0] TPC_WR_REG  = 4'hB;
  localparam logic [3:0] TPC_WR_LONG = 4'hD;

  localparam int STS_DONE = 7;
  localparam int STS_ERR  = 6;
  localparam int STS_RDY  = 5;
  localparam int STS_INV  = 0;

  localparam int ADDR_STS   = 'h01;
  localparam int ADDR_TYPE  = 'h04;
  localparam int ADDR_CAT   = 'h06;
  localparam int ADDR_CLASS = 'h07;
  localparam int ADDR_CFG   = 'h10;
  localparam int CFG_1BIT   = 7;

  typedef enum logic [1:0] {
    M_NONE,
    M_WIN,
    M_WR,
    M_RD
  } mode_e;
endpackage

// File: rtl/card_regfile_win.sv
module card_regfile_win
  import card_regfile_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tpc_valid_i,
  input  logic [3:0]    tpc_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rd_i,
  input  logic          sts_rdy_i,
  output logic [DW-1:0] xfer_len_o,
  output logic [DW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic          rd_act_o,
  output logic          long_go_o
);
  logic [DW-1:0] rd_start_q, rd_cnt_q, wr_start_q, wr_cnt_q;
  logic [DW-1:0] ptr_q, rem_q, len_q;
  logic [1:0]    idx_q;
  logic          long_q;
  mode_e         mode_q;

  logic busy;
  assign busy     = rem_q != '0;
  assign wr_en_o  = (mode_q == M_WR) && busy && byte_valid_i && !tpc_valid_i;
  assign rd_act_o = (mode_q == M_RD) && busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_start_q <= '0;
      rd_cnt_q   <= '0;
      wr_start_q <= '0;
      wr_cnt_q   <= '0;
      ptr_q      <= '0;
      rem_q      <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      long_q     <= 1'b0;
      mode_q     <= M_NONE;
    end else if (tpc_valid_i) begin
      idx_q  <= '0;
      long_q <= ((tpc_i == TPC_RD_LONG) || (tpc_i == TPC_WR_LONG)) && sts_rdy_i;
      unique case (tpc_i)
        TPC_SET_WIN: begin
          mode_q <= M_WIN; rem_q <= DW'(4); len_q <= DW'(4);
        end
        TPC_WR_REG: begin
          mode_q <= M_WR; ptr_q <= wr_start_q; rem_q <= wr_cnt_q; len_q <= wr_cnt_q;
        end
        TPC_RD_REG: begin
          mode_q <= M_RD; ptr_q <= rd_start_q; rem_q <= rd_cnt_q; len_q <= rd_cnt_q;
        end
        TPC_GET_STS: begin
          mode_q <= M_RD; ptr_q <= DW'(ADDR_STS); rem_q <= DW'(1); len_q <= DW'(1);
        end
        default: begin
          mode_q <= M_NONE; rem_q <= '0; len_q <= '0;
        end
      endcase
    end else begin
      long_q <= 1'b0;
      if (busy) begin
        if (mode_q == M_WIN && byte_valid_i) begin
          unique case (idx_q)
            2'd0: rd_start_q <= byte_i;
            2'd1: rd_cnt_q   <= byte_i;
            2'd2: wr_start_q <= byte_i;
            default: wr_cnt_q <= byte_i;
          endcase
          idx_q <= idx_q + 1'b1;
          rem_q <= rem_q - 1'b1;
        end else if ((mode_q == M_WR && byte_valid_i) || (mode_q == M_RD && rd_i)) begin
          ptr_q <= ptr_q + 1'b1;
          rem_q <= rem_q - 1'b1;
        end
      end
    end
  end

  assign xfer_len_o = len_q;
  assign ptr_o      = ptr_q;
  assign long_go_o  = long_q;
endmodule

// File: rtl/card_regfile_store.sv
module card_regfile_store
  import card_regfile_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] sts_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] cfg_o
);
  localparam int WBASE = ADDR_CFG;
  localparam int NW    = NREGS - WBASE;
  localparam int IW    = (NW > 1) ? $clog2(NW) : 1;

  logic [DW-1:0] mem [NW];
  logic          in_rng;
  logic [DW-1:0] off;

  assign in_rng = (addr_i >= DW'(WBASE)) && (addr_i < DW'(NREGS));
  assign off    = addr_i - DW'(WBASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
      mem[0][CFG_1BIT] <= 1'b1;
    end else if (wr_en_i && in_rng) begin
      mem[off[IW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_rng) begin
      rdata_o = mem[off[IW-1:0]];
    end else begin
      unique case (addr_i)
        DW'(ADDR_STS):   rdata_o = sts_i;
        DW'(ADDR_TYPE):  rdata_o = DW'(8'h01);
        DW'(ADDR_CAT):   rdata_o = '0;
        DW'(ADDR_CLASS): rdata_o = '0;
        default:         rdata_o = '0;
      endcase
    end
  end

  assign cfg_o = mem[0];
endmodule

// File: rtl/card_regfile_idle.sv
module card_regfile_idle
  import card_regfile_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          idle_i,
  input  logic          bus4_i,
  input  logic [DW-1:0] sts_i,
  output logic [3:0]    dat_o
);
  localparam int LANE_BIT [4] = '{STS_DONE, STS_ERR, STS_RDY, STS_INV};
  logic [3:0] lanes;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lanes[g] = sts_i[LANE_BIT[g]];
  end

  always_comb begin
    if (!idle_i)     dat_o = 4'b0000;
    else if (bus4_i) dat_o = lanes;
    else             dat_o = {3'b000, |lanes};
  end
endmodule

// File: rtl/card_regfile.sv
module card_regfile
  import card_regfile_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tpc_valid_i,
  input  logic [3:0]    tpc_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] xfer_len_o,
  output logic          long_go_o,
  input  logic          sts_we_i,
  input  logic [DW-1:0] sts_i,
  input  logic          idle_i,
  output logic          bus_4bit_o,
  output logic [3:0]    dat_o
);
  logic [DW-1:0] sts_q;
  logic [DW-1:0] ptr, st_rdata, cfg;
  logic          wr_en, rd_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sts_q <= '0;
    else if (sts_we_i) sts_q <= sts_i;
  end

  card_regfile_win #(.DW(DW)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tpc_valid_i  (tpc_valid_i),
    .tpc_i        (tpc_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .rd_i         (rd_i),
    .sts_rdy_i    (sts_q[STS_RDY]),
    .xfer_len_o   (xfer_len_o),
    .ptr_o        (ptr),
    .wr_en_o      (wr_en),
    .rd_act_o     (rd_act),
    .long_go_o    (long_go_o)
  );

  card_regfile_store #(.DW(DW), .NREGS(NREGS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (ptr),
    .wdata_i (byte_i),
    .sts_i   (sts_q),
    .rdata_o (st_rdata),
    .cfg_o   (cfg)
  );

  assign bus_4bit_o = ~cfg[CFG_1BIT];
  assign rd_data_o  = rd_act ? st_rdata : '0;

  card_regfile_idle #(.DW(DW)) u_idle (
    .idle_i (idle_i),
    .bus4_i (bus_4bit_o),
    .sts_i  (sts_q),
    .dat_o  (dat_o)
  );
endmodule

// File: rtl/card_regfile_chk.sv
module card_regfile_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tpc_valid_i,
  input logic [3:0]    tpc_i,
  input logic          byte_valid_i,
  input logic [DW-1:0] sts_q,
  input logic [DW-1:0] rd_data_o,
  input logic [DW-1:0] xfer_len_o,
  input logic          long_go_o,
  input logic          idle_i,
  input logic          bus_4bit_o,
  input logic [3:0]    dat_o
);
  p_win_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpc_valid_i && tpc_i == 4'h8) |=> (xfer_len_o == DW'(4)));

  p_get_sts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpc_valid_i && tpc_i == 4'h7) |=> (xfer_len_o == DW'(1) && rd_data_o == sts_q));

  p_long_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_go_o |-> ($past(tpc_valid_i) && $past(sts_q[5])));

  p_cfg_by_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_4bit_o) |-> $past(byte_valid_i));

  p_one_bit_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !bus_4bit_o) |-> (dat_o[3:1] == 3'b000 &&
                                 dat_o[0] == (sts_q[7] | sts_q[6] | sts_q[5] | sts_q[0])));

  p_busy_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> (dat_o == 4'b0000));
endmodule

bind card_regfile card_regfile_chk #(.DW(DW)) u_chk (.*);

// File: tb/card_regfile_test.sv
module card_regfile_test;
  localparam int DW = 8;
  localparam int NREGS = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tpc_valid_i = 1'b0;
  logic [3:0] tpc_i = '0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic rd_i = 1'b0;
  logic sts_we_i = 1'b0;
  logic [7:0] sts_i = '0;
  logic idle_i = 1'b0;
  logic [7:0] rd_data_o, xfer_len_o;
  logic long_go_o, bus_4bit_o;
  logic [3:0] dat_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] mem_m [256];
  logic [7:0] sts_m = '0;
  logic [7:0] rs_m = '0, rc_m = '0, ws_m = '0, wc_m = '0;

  always #2.5 clk = ~clk;

  card_regfile #(.DW(DW), .NREGS(NREGS)) uut (.clk_i(clk), .*);

  function automatic logic [7:0] model_rd(logic [7:0] a);
    if (a >= 8'h10 && a < 8'(NREGS)) return mem_m[a];
    if (a == 8'h01) return sts_m;
    if (a == 8'h04) return 8'h01;
    return 8'h00;
  endfunction

  function automatic logic [3:0] model_dat(logic idle, logic bus4, logic [7:0] s);
    logic [3:0] l;
    l = {s[0], s[5], s[6], s[7]};
    if (!idle) return 4'b0;
    if (bus4) return l;
    return {3'b0, |l};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_tpc(logic [3:0] c);
    tpc_valid_i = 1'b1; tpc_i = c;
    @(negedge clk);
    tpc_valid_i = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    b = rd_data_o;
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic load_sts(logic [7:0] v);
    sts_we_i = 1'b1; sts_i = v;
    @(negedge clk);
    sts_we_i = 1'b0;
    sts_m = v;
    @(negedge clk);
  endtask

  task automatic set_win(logic [7:0] rs, logic [7:0] rc, logic [7:0] ws, logic [7:0] wc);
    do_tpc(4'h8);
    chk("R2 window length", xfer_len_o, 4);
    send_byte(rs); send_byte(rc); send_byte(ws); send_byte(wc);
    rs_m = rs; rc_m = rc; ws_m = ws; wc_m = wc;
  endtask

  task automatic reg_write(int extra);
    logic [7:0] b;
    do_tpc(4'hB);
    chk("R3 write length", xfer_len_o, wc_m);
    for (int i = 0; i < wc_m + extra; i++) begin
      b = 8'($urandom);
      send_byte(b);
      if (i < wc_m) begin
        logic [7:0] a;
        a = 8'(ws_m + i);
        if (a >= 8'h10 && a < 8'(NREGS)) mem_m[a] = b;
      end
    end
  endtask

  task automatic reg_read(string req);
    logic [7:0] b;
    do_tpc(4'h4);
    chk("R4 read length", xfer_len_o, rc_m);
    for (int i = 0; i < rc_m; i++) begin
      read_byte(b);
      chk(req, b, model_rd(8'(rs_m + i)));
    end
  endtask

  task automatic idle_chk(logic idle, logic [7:0] s);
    load_sts(s);
    idle_i = idle;
    #1;
    chk("R10 idle lanes", dat_o, model_dat(idle, bus_4bit_o, s));
    @(negedge clk);
    idle_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    mem_m[8'h10] = 8'h80;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 bus width", bus_4bit_o, 0);
    chk("R1 long idle", long_go_o, 0);
    do_tpc(4'h4);
    chk("R1 read count zero", xfer_len_o, 0);
    do_tpc(4'hB);
    chk("R1 write count zero", xfer_len_o, 0);
    do_tpc(4'h7);
    read_byte(b);
    chk("R1 status clear", b, 0);

    // R7 identification, R6 read-only low block
    set_win(8'h00, 8'h10, 8'h01, 8'h07);
    reg_write(0);
    reg_read("R7 id and R6 read-only");

    // R6 out of range
    set_win(8'h1C, 8'h08, 8'h1D, 8'h06);
    reg_write(2);
    reg_read("R6 range edge");

    // R8 config
    set_win(8'h10, 8'h01, 8'h10, 8'h01);
    do_tpc(4'hB);
    send_byte(8'h00); mem_m[8'h10] = 8'h00;
    @(negedge clk);
    chk("R8 4-bit selected", bus_4bit_o, 1);
    reg_read("R8 cfg readback");

    // R10 4-bit idle lanes
    idle_chk(1'b1, 8'h81);
    idle_chk(1'b1, 8'h20);
    idle_chk(1'b1, 8'h40);
    idle_chk(1'b0, 8'hE1);

    // R5 status read
    load_sts(8'hA1);
    do_tpc(4'h7);
    chk("R5 status length", xfer_len_o, 1);
    read_byte(b);
    chk("R5 status value", b, 8'hA1);

    // R9 long gating
    load_sts(8'h80);
    do_tpc(4'hD);
    chk("R9 long write not ready", long_go_o, 0);
    do_tpc(4'h2);
    chk("R9 long read not ready", long_go_o, 0);
    load_sts(8'h20);
    do_tpc(4'h2);
    chk("R9 long read ready", long_go_o, 1);
    @(negedge clk);
    chk("R9 single pulse", long_go_o, 0);
    do_tpc(4'hD);
    chk("R9 long write ready", long_go_o, 1);
    do_tpc(4'h4);
    chk("R9 non-long code", long_go_o, 0);

    // R8 back to 1-bit, R10 one-bit summary
    set_win(8'h10, 8'h01, 8'h10, 8'h01);
    do_tpc(4'hB);
    send_byte(8'h80); mem_m[8'h10] = 8'h80;
    @(negedge clk);
    chk("R8 1-bit selected", bus_4bit_o, 0);
    idle_chk(1'b1, 8'h40);
    idle_chk(1'b1, 8'h1E);
    idle_chk(1'b1, 8'h01);

    // random windows
    for (int k = 0; k < 40; k++) begin
      set_win(8'($urandom_range(0, 40)), 8'($urandom_range(0, 12)),
              8'($urandom_range(0, 40)), 8'($urandom_range(0, 12)));
      reg_write($urandom_range(0, 2));
      reg_read("R3 R4 random window");
      if (k % 8 == 0) begin
        load_sts(8'($urandom));
        do_tpc(4'h7);
        read_byte(b);
        chk("R5 random status", b, sts_m);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule